// File: doc/BRIEF.md
# Programmable Burst Pulse Generator

This block is a pulse-train generator for a 40 MHz trigger logic system. After it is enabled, it waits for a start-up quiet period. It then emits pulses of a set width, separated by a set gap. It stops after a set number of pulses, or it keeps running without limit. In repeat mode it starts the whole sequence again after the last pulse. The same block can make a long spill window, a shutter that an outside signal cuts short, or a stream of single-cycle triggers counted up to a limit.

The enable source is chosen from a vector of candidate signals by a select field. The force-zero source is chosen from a second vector by a second select field. Several instances can be chained. One instance's pulse output can drive another instance's enable, and one instance's limit flag can drive another instance's force-zero. All timing values are given in clock cycles through plain configuration ports, which are assumed to be held steady while a sequence runs.

Top module: `burst_pulser`

## Requirements
- R1: While `rst_n` is low, and in the cycle after release while the selected enable is low, `pulse_o` and `max_reached_o` are 0.
- R2: After a rising edge of the selected enable is sampled at clock edge E, no pulse appears for `cfg_start_dead` cycles. The first pulse is high in the state that follows edge E + `cfg_start_dead`. A value of 0 makes the first pulse start right after edge E.
- R3: Each pulse stays high for `cfg_pulse_len` cycles. A value of 0 is treated as 1.
- R4: Successive pulses are separated by `cfg_gap` low cycles. With a gap of 0, successive pulses merge into one continuous high level.
- R5: With `cfg_max_pulses` = M > 0 and `cfg_repeat` = 0, generation stops after M pulses. `max_reached_o` then rises and stays high until the enable falls or reset is applied. M = 0 means there is no limit, and `max_reached_o` never rises.
- R6: With `cfg_repeat` = 1 and M > 0, the cycle after the M-th pulse ends starts the sequence again from the start-up quiet period, with the pulse count cleared. `max_reached_o` is high for exactly that one cycle.
- R7: `pulse_o` is the internal pulse train delayed by `cfg_out_delay` cycles, from 0 to 255. A value of 0 means no delay.
- R8: Only `en_src[cfg_en_sel]` acts as the enable. The unselected bits have no effect. While the selected enable is low, the generator is idle, makes no new pulse, and holds `max_reached_o` at 0.
- R9: A new rising edge of the selected enable, after it has been low, restarts the sequence from the start-up quiet period with a fresh pulse count.
- R10: While `fz_src[cfg_fz_sel]` is high, `pulse_o` is 0 in that same cycle. The force is applied after the delay, and the unselected force bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_start_dead | input | CNT_W | quiet cycles before the first pulse |
| cfg_pulse_len | input | CNT_W | pulse width in cycles (0 acts as 1) |
| cfg_gap | input | CNT_W | low cycles between pulses |
| cfg_max_pulses | input | PCNT_W | pulse limit, 0 for no limit |
| cfg_out_delay | input | DLY_W | output delay in cycles |
| cfg_repeat | input | 1 | 1 restarts the sequence after the limit |
| cfg_en_sel | input | EN_SEL_W | index of the enable source |
| cfg_fz_sel | input | FZ_SEL_W | index of the force-zero source |
| en_src | input | N_EN | candidate enable sources |
| fz_src | input | N_FZ | candidate force-zero sources |
| pulse_o | output | 1 | gated, delayed pulse output |
| max_reached_o | output | 1 | pulse limit reached flag |

## Verification
The bench runs directed sequences first. These are a plain limited burst, single-cycle triggers with no gap, the longest output delay, zero pulse length, an unlimited count, repeat mode, and an enable that drops in mid-sequence and then rises again. Together they separate the start-up quiet period from the gap, and a stop from a restart. After that come seeded random configurations. In these, the unselected enable and force bits toggle every cycle, and the selected force bit is pulsed at random. A bench model computes each expected cycle from the phase arithmetic alone: the quiet period, then the period of pulse plus gap, taken modulo the whole sequence length in repeat mode. A timing error of even one cycle in any phase, in the delay, or in the mux index therefore shows up at the pins.

// File: rtl/burst_pulser_pkg.sv
// Package: shared types for the burst pulse generator.
// Assumes nothing beyond IEEE 1800-2017 enumerations.
package burst_pulser_pkg;

    // Sequencer phases of the pulse generator
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_DEAD,
        ST_PULSE,
        ST_GAP,
        ST_DONE
    } pulser_state_t;

endpackage

// File: rtl/src_select.sv
// Module: src_select
// Picks one bit out of a vector of candidate sources by index.
// An index beyond the vector yields 0. Purely combinational.
module src_select #(
    parameter int N     = 4,
    parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             bit_o
);

    // Indexed pick with an out-of-range guard
    always_comb begin
        if (int'(sel_i) < N) bit_o = src_i[sel_i];
        else                 bit_o = 1'b0;
    end

endmodule

// File: rtl/pulse_fsm.sv
// Module: pulse_fsm
// Sequencer of the pulser: quiet period, pulses, gaps, limit handling.
// Assumes configuration is stable while enabled; enable is already selected.
module pulse_fsm
    import burst_pulser_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [CNT_W-1:0]  start_dead_i,
    input  logic [CNT_W-1:0]  pulse_len_i,
    input  logic [CNT_W-1:0]  gap_i,
    input  logic [PCNT_W-1:0] max_pulses_i,
    input  logic              repeat_i,
    output logic              raw_o,
    output logic              limit_o,
    output pulser_state_t     state_o
);

    pulser_state_t     st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [PCNT_W-1:0] np_q, np_d;
    logic              en_q;
    logic              strobe_q, strobe_d;
    logic              en_rise;
    logic              final_pulse;
    logic [CNT_W-1:0]  plen_last;
    logic [PCNT_W:0]   np_inc;

    assign en_rise     = enable_i & ~en_q;
    assign plen_last   = (pulse_len_i == '0) ? '0 : pulse_len_i - 1'b1;
    assign np_inc      = {1'b0, np_q} + 1'b1;
    assign final_pulse = (max_pulses_i != '0) && (np_inc == {1'b0, max_pulses_i});

    // Next-state and counter computation
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        np_d     = np_q;
        strobe_d = 1'b0;
        if (!enable_i) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
            np_d  = '0;
        end else if (en_rise) begin
            np_d = '0;
            if (start_dead_i == '0) begin
                st_d  = ST_PULSE;
                cnt_d = plen_last;
            end else begin
                st_d  = ST_START_DEAD;
                cnt_d = start_dead_i - 1'b1;
            end
        end else begin
            case (st_q)
                ST_START_DEAD: begin
                    if (cnt_q == '0) begin
                        st_d  = ST_PULSE;
                        cnt_d = plen_last;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - 1'b1;
                    end else if (final_pulse) begin
                        np_d = '0;
                        if (repeat_i) begin
                            strobe_d = 1'b1;
                            if (start_dead_i == '0) begin
                                st_d  = ST_PULSE;
                                cnt_d = plen_last;
                            end else begin
                                st_d  = ST_START_DEAD;
                                cnt_d = start_dead_i - 1'b1;
                            end
                        end else begin
                            st_d = ST_DONE;
                        end
                    end else begin
                        np_d = np_inc[PCNT_W-1:0];
                        if (gap_i == '0) begin
                            st_d  = ST_PULSE;
                            cnt_d = plen_last;
                        end else begin
                            st_d  = ST_GAP;
                            cnt_d = gap_i - 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (cnt_q == '0) begin
                        st_d  = ST_PULSE;
                        cnt_d = plen_last;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    // State, counters and enable history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            np_q     <= '0;
            en_q     <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            np_q     <= np_d;
            en_q     <= enable_i;
            strobe_q <= strobe_d;
        end
    end

    assign raw_o   = (st_q == ST_PULSE);
    assign limit_o = (st_q == ST_DONE) | strobe_q;
    assign state_o = st_q;

endmodule

// File: rtl/delay_line.sv
// Module: delay_line
// Shift-register delay with a selectable tap; tap 0 passes the input.
// Assumes DLY_MAX fits in DLY_W bits; contents clear on reset.
module delay_line #(
    parameter int DLY_MAX = 255,
    parameter int DLY_W   = $clog2(DLY_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             q_o
);

    logic [DLY_MAX-1:0] sr_q;

    // Shift one stage per clock
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[DLY_MAX-2:0], d_i};
    end

    // Tap selection
    always_comb begin
        if (dly_i == '0)                  q_o = d_i;
        else if (int'(dly_i) <= DLY_MAX)  q_o = sr_q[dly_i - 1'b1];
        else                              q_o = 1'b0;
    end

endmodule

// File: rtl/burst_pulser.sv
// Module: burst_pulser (top)
// Programmable burst pulse generator with selectable enable and force-zero
// sources and a delayed, gated output. Assumes a single 40 MHz clock domain
// and configuration held stable while the selected enable is high.
module burst_pulser
    import burst_pulser_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PCNT_W   = 16,
    parameter int DLY_MAX  = 255,
    parameter int N_EN     = 4,
    parameter int N_FZ     = 4,
    localparam int DLY_W    = $clog2(DLY_MAX + 1),
    localparam int EN_SEL_W = (N_EN > 1) ? $clog2(N_EN) : 1,
    localparam int FZ_SEL_W = (N_FZ > 1) ? $clog2(N_FZ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    cfg_start_dead,
    input  logic [CNT_W-1:0]    cfg_pulse_len,
    input  logic [CNT_W-1:0]    cfg_gap,
    input  logic [PCNT_W-1:0]   cfg_max_pulses,
    input  logic [DLY_W-1:0]    cfg_out_delay,
    input  logic                cfg_repeat,
    input  logic [EN_SEL_W-1:0] cfg_en_sel,
    input  logic [FZ_SEL_W-1:0] cfg_fz_sel,
    input  logic [N_EN-1:0]     en_src,
    input  logic [N_FZ-1:0]     fz_src,
    output logic                pulse_o,
    output logic                max_reached_o
);

    logic          en_sel;
    logic          fz_sel;
    logic          raw_pulse;
    logic          tap;
    pulser_state_t fsm_state;

    src_select #(.N(N_EN), .SEL_W(EN_SEL_W)) u_en_mux (
        .src_i (en_src),
        .sel_i (cfg_en_sel),
        .bit_o (en_sel)
    );

    src_select #(.N(N_FZ), .SEL_W(FZ_SEL_W)) u_fz_mux (
        .src_i (fz_src),
        .sel_i (cfg_fz_sel),
        .bit_o (fz_sel)
    );

    pulse_fsm #(.CNT_W(CNT_W), .PCNT_W(PCNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (en_sel),
        .start_dead_i (cfg_start_dead),
        .pulse_len_i  (cfg_pulse_len),
        .gap_i        (cfg_gap),
        .max_pulses_i (cfg_max_pulses),
        .repeat_i     (cfg_repeat),
        .raw_o        (raw_pulse),
        .limit_o      (max_reached_o),
        .state_o      (fsm_state)
    );

    delay_line #(.DLY_MAX(DLY_MAX), .DLY_W(DLY_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_pulse),
        .dly_i (cfg_out_delay),
        .q_o   (tap)
    );

    // Force-zero gating after the delay
    assign pulse_o = tap & ~fz_sel;

endmodule

// File: rtl/burst_pulser_chk.sv
// Module: burst_pulser_chk
// Temporal checks on the pulser, bound into every burst_pulser instance.
// Assumes synchronous active-low reset; all properties idle during reset.
module burst_pulser_chk
    import burst_pulser_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_sel,
    input  logic             fz_sel,
    input  logic             raw_pulse,
    input  pulser_state_t    fsm_state,
    input  logic             pulse_o,
    input  logic             max_reached_o,
    input  logic [DLY_W-1:0] cfg_out_delay
);

    // R8: a low enable leaves no pulse in the following state
    a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_sel |=> !raw_pulse);

    // R10: selected force-zero blanks the output
    a_r10_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        fz_sel |-> !pulse_o);

    // R7: with zero delay and no force, output follows the sequencer
    a_r7_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out_delay == '0 && !fz_sel) |-> (pulse_o == raw_pulse));

    // R5: finished state under enable keeps the limit flag high
    a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DONE && en_sel) |=> max_reached_o);

    // R9: an enable rising edge restarts the sequence
    a_r9_rise_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (en_sel && !$past(en_sel)) |=> (fsm_state == ST_START_DEAD || fsm_state == ST_PULSE));

endmodule

bind burst_pulser burst_pulser_chk #(.DLY_W(DLY_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_sel        (en_sel),
    .fz_sel        (fz_sel),
    .raw_pulse     (raw_pulse),
    .fsm_state     (fsm_state),
    .pulse_o       (pulse_o),
    .max_reached_o (max_reached_o),
    .cfg_out_delay (cfg_out_delay)
);

// File: tb/test_burst_pulser.sv
// Bench for burst_pulser: directed corners plus seeded random configurations,
// compared cycle by cycle against a phase-arithmetic model.
module test_burst_pulser;

    localparam int CNT_W    = 16;
    localparam int PCNT_W   = 16;
    localparam int DLY_MAX  = 255;
    localparam int N_EN     = 4;
    localparam int N_FZ     = 4;
    localparam int DLY_W    = 8;
    localparam int EN_SEL_W = 2;
    localparam int FZ_SEL_W = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [CNT_W-1:0]    cfg_start_dead = '0;
    logic [CNT_W-1:0]    cfg_pulse_len = '0;
    logic [CNT_W-1:0]    cfg_gap = '0;
    logic [PCNT_W-1:0]   cfg_max_pulses = '0;
    logic [DLY_W-1:0]    cfg_out_delay = '0;
    logic                cfg_repeat = 1'b0;
    logic [EN_SEL_W-1:0] cfg_en_sel = '0;
    logic [FZ_SEL_W-1:0] cfg_fz_sel = '0;
    logic [N_EN-1:0]     en_src = '0;
    logic [N_FZ-1:0]     fz_src = '0;
    logic                pulse_o;
    logic                max_reached_o;

    int  errors = 0;
    int  checks = 0;
    int  cycles = 0;
    bit  done   = 1'b0;
    bit  exp_raw [0:4095];

    burst_pulser i_burst_pulser (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_start_dead (cfg_start_dead),
        .cfg_pulse_len  (cfg_pulse_len),
        .cfg_gap        (cfg_gap),
        .cfg_max_pulses (cfg_max_pulses),
        .cfg_out_delay  (cfg_out_delay),
        .cfg_repeat     (cfg_repeat),
        .cfg_en_sel     (cfg_en_sel),
        .cfg_fz_sel     (cfg_fz_sel),
        .en_src         (en_src),
        .fz_src         (fz_src),
        .pulse_o        (pulse_o),
        .max_reached_o  (max_reached_o)
    );

    always #4 clk = ~clk;

    // Watchdog: an expired run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(bit act, bit exp, string tag, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Expected sequencer output m cycles after the enable edge
    function automatic bit model_raw(int m, int sd, int pl, int gap, int mx, bit rep);
        int ple, len, p, k, r, mm;
        ple = (pl == 0) ? 1 : pl;
        len = sd + mx * ple + (mx - 1) * gap;
        mm  = m;
        if (rep && mx > 0) mm = mm % len;
        if (mm < sd) return 1'b0;
        mm = mm - sd;
        p  = ple + gap;
        k  = mm / p;
        r  = mm % p;
        if (mx > 0 && k >= mx) return 1'b0;
        return (r < ple);
    endfunction

    // Expected limit flag m cycles after the enable edge
    function automatic bit model_max(int m, int sd, int pl, int gap, int mx, bit rep);
        int ple, len;
        if (mx == 0) return 1'b0;
        ple = (pl == 0) ? 1 : pl;
        len = sd + mx * ple + (mx - 1) * gap;
        if (rep) return (m > 0 && (m % len) == 0);
        return (m >= len);
    endfunction

    task automatic run(int sd, int pl, int gap, int mx, int d, bit rep,
                       int esel, int fsel, int fzpct, int drop, int len);
        bit en_cur, en_prev, fzv, tap, emax;
        int org;
        string ptag, mtag;
        rst_n  = 1'b0;
        en_src = '0;
        fz_src = '0;
        @(negedge clk);
        cfg_start_dead = CNT_W'(sd);
        cfg_pulse_len  = CNT_W'(pl);
        cfg_gap        = CNT_W'(gap);
        cfg_max_pulses = PCNT_W'(mx);
        cfg_out_delay  = DLY_W'(d);
        cfg_repeat     = rep;
        cfg_en_sel     = EN_SEL_W'(esel);
        cfg_fz_sel     = FZ_SEL_W'(fsel);
        repeat (2) @(negedge clk);
        check(pulse_o, 1'b0, "R1", "pulse_o in reset");
        check(max_reached_o, 1'b0, "R1", "max_reached_o in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(pulse_o, 1'b0, "R1", "pulse_o idle after reset");
        check(max_reached_o, 1'b0, "R1", "max_reached_o idle after reset");
        en_cur  = 1'b1;
        en_prev = 1'b0;
        org     = 0;
        en_src  = N_EN'($urandom);
        en_src[esel] = en_cur;
        for (int n = 0; n < len; n++) begin
            @(negedge clk);
            if (en_cur && !en_prev) org = n;
            exp_raw[n] = en_cur ? model_raw(n - org, sd, pl, gap, mx, rep) : 1'b0;
            emax       = en_cur ? model_max(n - org, sd, pl, gap, mx, rep) : 1'b0;
            fzv        = (int'($urandom_range(99)) < fzpct);
            fz_src     = N_FZ'($urandom);
            fz_src[fsel] = fzv;
            #1;
            tap  = (n >= d) ? exp_raw[n - d] : 1'b0;
            ptag = fzv ? "R10" : ((drop >= 0 && n >= drop) ? "R8 R9" : "R2 R3 R4 R7");
            mtag = rep ? "R6" : "R5";
            check(pulse_o, tap & ~fzv, ptag, $sformatf("pulse_o cycle %0d", n));
            check(max_reached_o, emax, mtag, $sformatf("max_reached_o cycle %0d", n));
            en_prev = en_cur;
            en_cur  = !(drop >= 0 && n + 1 >= drop && n + 1 < drop + 5);
            en_src  = N_EN'($urandom);
            en_src[esel] = en_cur;
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = int'($urandom(32'd20240611));
        // R2 R3 R4 R5: plain limited burst
        run(3, 2, 1, 3, 0, 1'b0, 0, 1, 0, -1, 40);
        // R3 R4 R5: single-cycle triggers, zero gap, limit of five
        run(0, 1, 0, 5, 0, 1'b0, 2, 3, 0, -1, 30);
        // R7: longest delay
        run(2, 3, 2, 2, 255, 1'b0, 1, 0, 0, -1, 300);
        // R3: zero pulse length acts as one
        run(1, 0, 2, 4, 3, 1'b0, 3, 2, 0, -1, 40);
        // R5: unlimited count, flag never rises
        run(2, 2, 2, 0, 0, 1'b0, 0, 0, 0, -1, 60);
        // R6: repeat mode restarts with one-cycle flag
        run(2, 2, 1, 2, 0, 1'b1, 1, 1, 0, -1, 60);
        // R6: repeat with no quiet period
        run(0, 1, 1, 3, 1, 1'b1, 2, 0, 0, -1, 40);
        // R8 R9: enable drops mid-run then rises again
        run(1, 3, 2, 0, 4, 1'b0, 3, 3, 0, 9, 60);
        // R10: heavy force-zero over a long pulse
        run(0, 20, 0, 1, 2, 1'b0, 0, 2, 40, -1, 40);
        // Random mix over all requirements
        for (int i = 0; i < 32; i++) begin
            run(int'($urandom_range(6)), int'($urandom_range(4)), int'($urandom_range(3)),
                int'($urandom_range(4)), int'($urandom_range(30)), 1'($urandom_range(1)),
                int'($urandom_range(3)), int'($urandom_range(3)),
                ($urandom_range(1) == 1) ? 20 : 0,
                ($urandom_range(2) == 0) ? int'($urandom_range(60, 10)) : -1, 150);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule